// File: doc/BRIEF.md
# Run-Control Halt and Event Monitor

This block sits beside a processor core and watches its instruction-retire stream to decide when a test run must stop. Each retire presents the program counter of the instruction that just finished, the program counter it moves on to, and a flag marking the idle instruction. The monitor counts retired instructions. It halts the run when the next program counter matches an enabled stop address, when an instruction leaves the program counter unchanged, when an idle instruction retires with nothing to wake the core, or when the retire count reaches a programmable limit. A halt is latched with a 2-bit cause code and held, with the counter frozen, until a synchronous clear.

The monitor also injects interrupts for exercising service routines. A small table of entries, each holding a priority level and a retire count, raises a one-cycle interrupt request once the counter reaches that count. All settings are loaded through a simple register write port.

Top module: `rc_halt_monitor`

## Requirements
- R1: After reset, `halted`, `irq_req`, `halt_reason` and `step_count` are all zero. Every stop entry and every interrupt entry is disabled, and the step limit is 1,000,000.
- R2: While not halted, `step_count` rises by exactly one on each cycle with `ret_valid` high and holds on every other cycle.
- R3: Stop entries sit at write addresses 0 to 3, with bit 16 as the enable and bits 15:0 as the address. A retire whose `ret_pc_post` equals an enabled entry halts with cause 01. A disabled entry never halts.
- R4: A retire with `ret_pc_post` equal to `ret_pc_pre` halts with cause 10.
- R5: A retire with `ret_idle` high halts with cause 00, unless a wake source is present. Wake sources are: `irq_pending` is high, `irq_req` is high, or an armed interrupt entry's count equals the count reached by this retire.
- R6: The step limit sits at write address 8, bits 23:0. A retire that brings `step_count` to a value at or above the limit halts with cause 11.
- R7: When several causes occur on one retire, the stop address wins first, then loop, then idle, then the step limit.
- R8: A halt keeps `halted`, `halt_reason` and `step_count` unchanged, and retires are ignored, until `clr_halt` is high. `clr_halt` drops the halt and zeroes `step_count`, and it takes precedence over a retire in the same cycle.
- R9: Interrupt entries sit at write addresses 4 to 7, with bit 31 as arm, bits 27:24 as level and bits 23:0 as count. While not halted, an armed entry whose count equals `step_count` disarms. In the next cycle, `irq_req` is high for one cycle with `irq_level` set to that level.
- R10: When several armed entries match in the same cycle, all of them disarm and a single request carries the numerically lowest level.
- R11: The retire that causes a halt is itself counted in `step_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_halt | input | 1 | Synchronous clear of halt and counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc_pre | input | 16 | Program counter before the retiring instruction |
| ret_pc_post | input | 16 | Program counter after the retiring instruction |
| ret_idle | input | 1 | The retiring instruction is the idle instruction |
| irq_pending | input | 1 | An externally pending interrupt that can wake the core |
| halted | output | 1 | Run has stopped |
| halt_reason | output | 2 | Cause: 00 idle, 01 stop address, 10 loop, 11 step limit |
| step_count | output | 24 | Retired instruction count |
| irq_req | output | 1 | One-cycle scheduled interrupt request |
| irq_level | output | 4 | Level of the scheduled request |

## Verification
The assertions assume that `clr_halt` and `rst` are plain synchronous pulses. They also assume that retire inputs are meaningful only while `ret_valid` is high. They do not constrain what happens when a configuration write and a retire land in the same cycle. The stimulus keeps configuration writes in cycles without a retire, so that ordering never arises. Under these conditions, the bench model and the design agree on which table contents a retire sees. Stop-address, loop, idle and limit causes are then driven alone and in overlapping pairs to exercise the priority order.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int PC_W        = 16;
    localparam int CNT_W       = 24;
    localparam int LVL_W       = 4;
    localparam int CFG_DW      = 32;
    localparam int STOP_EN_BIT = 16;
    localparam int IRQ_ARM_BIT = 31;
    localparam int IRQ_LVL_LSB = 24;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        HALT_IDLE = 2'b00,
        HALT_STOP = 2'b01,
        HALT_LOOP = 2'b10,
        HALT_MAX  = 2'b11
    } halt_cause_e;

    typedef struct packed {
        logic stop;
        logic loop;
        logic idle;
        logic maxed;
    } cause_set_t;

    typedef struct packed {
        logic valid;
        pc_t  addr;
    } stop_entry_t;

    typedef struct packed {
        logic armed;
        lvl_t level;
        cnt_t step;
    } irq_entry_t;

    function automatic logic any_cause(input cause_set_t c);
        return c.stop | c.loop | c.idle | c.maxed;
    endfunction

    // Fixed precedence: stop address, loop, idle, step limit.
    function automatic halt_cause_e pick_cause(input cause_set_t c);
        if (c.stop)      return HALT_STOP;
        else if (c.loop) return HALT_LOOP;
        else if (c.idle) return HALT_IDLE;
        else             return HALT_MAX;
    endfunction

    function automatic stop_entry_t unpack_stop(input logic [CFG_DW-1:0] d);
        stop_entry_t e;
        e.valid = d[STOP_EN_BIT];
        e.addr  = d[PC_W-1:0];
        return e;
    endfunction

    function automatic irq_entry_t unpack_irq(input logic [CFG_DW-1:0] d);
        irq_entry_t e;
        e.armed = d[IRQ_ARM_BIT];
        e.level = d[IRQ_LVL_LSB +: LVL_W];
        e.step  = d[CNT_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/rcm_cfg_regs.sv
module rcm_cfg_regs
    import rcm_pkg::*;
#(
    parameter int N_STOP      = 4,
    parameter int N_IRQ       = 4,
    parameter int CFG_AW      = 4,
    parameter int MAX_DEFAULT = 1000000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output stop_entry_t [N_STOP-1:0] stop_tab,
    output cnt_t                     max_steps
);
    localparam int LIMIT_ADDR = N_STOP + N_IRQ;

    for (genvar g = 0; g < N_STOP; g++) begin : g_stop
        always_ff @(posedge clk) begin
            if (rst)
                stop_tab[g] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
                stop_tab[g] <= unpack_stop(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            max_steps <= cnt_t'(MAX_DEFAULT);
        else if (cfg_we && cfg_addr == CFG_AW'(LIMIT_ADDR))
            max_steps <= cfg_wdata[CNT_W-1:0];
    end

endmodule

// File: rtl/rcm_stop_match.sv
module rcm_stop_match
    import rcm_pkg::*;
#(
    parameter int N_STOP = 4
) (
    input  stop_entry_t [N_STOP-1:0] stop_tab,
    input  pc_t                      pc,
    output logic                     hit
);
    logic [N_STOP-1:0] eq;

    for (genvar g = 0; g < N_STOP; g++) begin : g_cmp
        assign eq[g] = stop_tab[g].valid && (stop_tab[g].addr == pc);
    end

    assign hit = |eq;

endmodule

// File: rtl/rcm_irq_sched.sv
module rcm_irq_sched
    import rcm_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int CFG_AW   = 4,
    parameter int IRQ_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              run,
    input  cnt_t              cur_count,
    input  cnt_t              next_count,
    output logic              irq_req,
    output lvl_t              irq_level,
    output logic              wake_hit
);
    irq_entry_t [N_IRQ-1:0] tab;
    logic [N_IRQ-1:0]       fire;
    logic [N_IRQ-1:0]       ahead;
    lvl_t                   best;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_ent
        assign fire[g]  = run && tab[g].armed && (tab[g].step == cur_count);
        assign ahead[g] = tab[g].armed && (tab[g].step == next_count);

        always_ff @(posedge clk) begin
            if (rst)
                tab[g] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(IRQ_BASE + g))
                tab[g] <= unpack_irq(cfg_wdata);
            else if (fire[g])
                tab[g].armed <= 1'b0;
        end
    end

    // Most urgent level among simultaneous matches (lowest value).
    always_comb begin
        best = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (fire[i] && tab[i].level < best)
                best = tab[i].level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req   <= 1'b0;
            irq_level <= '0;
        end else begin
            irq_req <= |fire;
            if (|fire)
                irq_level <= best;
        end
    end

    assign wake_hit = |ahead;

endmodule

// File: rtl/rc_halt_monitor.sv
module rc_halt_monitor
    import rcm_pkg::*;
#(
    parameter int N_STOP      = 4,
    parameter int N_IRQ       = 4,
    parameter int CFG_AW      = 4,
    parameter int MAX_DEFAULT = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_halt,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              ret_valid,
    input  logic [PC_W-1:0]   ret_pc_pre,
    input  logic [PC_W-1:0]   ret_pc_post,
    input  logic              ret_idle,
    input  logic              irq_pending,
    output logic              halted,
    output logic [1:0]        halt_reason,
    output logic [CNT_W-1:0]  step_count,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    localparam int IRQ_BASE = N_STOP;

    stop_entry_t [N_STOP-1:0] stop_tab;
    cnt_t        max_steps;
    cnt_t        cnt_q;
    cnt_t        cnt_next;
    logic        halted_q;
    halt_cause_e reason_q;
    logic        stop_hit;
    logic        wake_hit;
    logic        irq_req_w;
    lvl_t        irq_level_w;
    logic        retire_ok;
    logic        wake;
    cause_set_t  causes;

    rcm_cfg_regs #(
        .N_STOP      (N_STOP),
        .N_IRQ       (N_IRQ),
        .CFG_AW      (CFG_AW),
        .MAX_DEFAULT (MAX_DEFAULT)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .stop_tab  (stop_tab),
        .max_steps (max_steps)
    );

    rcm_stop_match #(
        .N_STOP (N_STOP)
    ) u_match (
        .stop_tab (stop_tab),
        .pc       (ret_pc_post),
        .hit      (stop_hit)
    );

    rcm_irq_sched #(
        .N_IRQ    (N_IRQ),
        .CFG_AW   (CFG_AW),
        .IRQ_BASE (IRQ_BASE)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .run        (!halted_q),
        .cur_count  (cnt_q),
        .next_count (cnt_next),
        .irq_req    (irq_req_w),
        .irq_level  (irq_level_w),
        .wake_hit   (wake_hit)
    );

    assign retire_ok = ret_valid && !halted_q;
    assign cnt_next  = cnt_q + 1'b1;
    assign wake      = irq_pending || irq_req_w || wake_hit;

    always_comb begin
        causes.stop  = stop_hit;
        causes.loop  = (ret_pc_post == ret_pc_pre);
        causes.idle  = ret_idle && !wake;
        causes.maxed = (cnt_next >= max_steps);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            halted_q <= 1'b0;
            reason_q <= HALT_IDLE;
        end else if (clr_halt) begin
            cnt_q    <= '0;
            halted_q <= 1'b0;
            reason_q <= HALT_IDLE;
        end else if (retire_ok) begin
            cnt_q <= cnt_next;
            if (any_cause(causes)) begin
                halted_q <= 1'b1;
                reason_q <= pick_cause(causes);
            end
        end
    end

    assign halted      = halted_q;
    assign halt_reason = reason_q;
    assign step_count  = cnt_q;
    assign irq_req     = irq_req_w;
    assign irq_level   = irq_level_w;

endmodule

// File: rtl/rcm_halt_monitor_chk.sv
module rcm_halt_monitor_chk
    import rcm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_halt,
    input logic             ret_valid,
    input logic [PC_W-1:0]  ret_pc_pre,
    input logic [PC_W-1:0]  ret_pc_post,
    input logic             ret_idle,
    input logic             irq_pending,
    input logic             halted,
    input logic [1:0]       halt_reason,
    input logic [CNT_W-1:0] step_count,
    input logic             irq_req
);

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_halt |=> (!halted && step_count == '0)); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (halted && !clr_halt) |=> (halted && $stable(halt_reason) && $stable(step_count))); // R8

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!halted && !clr_halt && ret_valid) |=> (step_count == $past(step_count) + 1'b1)); // R2

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!halted && !clr_halt && !ret_valid) |=> $stable(step_count)); // R2

    AST_LOOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (!halted && !clr_halt && ret_valid && ret_pc_pre == ret_pc_post)
        |=> (halted && (halt_reason == HALT_LOOP || halt_reason == HALT_STOP))); // R4

    AST_IDLE_WOKEN: assert property (@(posedge clk) disable iff (rst)
        (!halted && !clr_halt && ret_valid && ret_idle && irq_pending)
        |=> (!halted || halt_reason != HALT_IDLE)); // R5

    AST_NO_IRQ_HALTED: assert property (@(posedge clk) disable iff (rst)
        (halted && !clr_halt) |=> !irq_req); // R9

endmodule

bind rc_halt_monitor rcm_halt_monitor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_halt    (clr_halt),
    .ret_valid   (ret_valid),
    .ret_pc_pre  (ret_pc_pre),
    .ret_pc_post (ret_pc_post),
    .ret_idle    (ret_idle),
    .irq_pending (irq_pending),
    .halted      (halted),
    .halt_reason (halt_reason),
    .step_count  (step_count),
    .irq_req     (irq_req)
);

// File: tb/rc_halt_monitor_tb.sv
`timescale 1ns/1ps
module rc_halt_monitor_tb;

    logic        clk = 1'b0;
    logic        rst, clr_halt, cfg_we, ret_valid, ret_idle, irq_pending;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [15:0] ret_pc_pre, ret_pc_post;
    logic        halted, irq_req;
    logic [1:0]  halt_reason;
    logic [23:0] step_count;
    logic [3:0]  irq_level;

    always #2 clk = ~clk;

    rc_halt_monitor u_dut (
        .clk(clk), .rst(rst), .clr_halt(clr_halt), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ret_valid(ret_valid),
        .ret_pc_pre(ret_pc_pre), .ret_pc_post(ret_pc_post), .ret_idle(ret_idle),
        .irq_pending(irq_pending), .halted(halted), .halt_reason(halt_reason),
        .step_count(step_count), .irq_req(irq_req), .irq_level(irq_level)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    bit m_h;   int m_r;  int m_cnt;  bit m_irq;  int m_lvl;  int m_max;
    bit m_sv[4]; int m_sa[4];
    bit m_arm[4]; int m_el[4]; int m_es[4];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_next();
        bit hit_any; int best; bit wk; bit s, l, i, x; int nc;
        bit fire[4];
        if (rst) begin
            m_h = 0; m_r = 0; m_cnt = 0; m_irq = 0; m_lvl = 0; m_max = 1000000;
            for (int k = 0; k < 4; k++) begin
                m_sv[k] = 0; m_sa[k] = 0; m_arm[k] = 0; m_el[k] = 0; m_es[k] = 0;
            end
            return;
        end
        nc = m_cnt + 1;
        wk = irq_pending || m_irq;
        hit_any = 0; best = 16;
        for (int k = 0; k < 4; k++) begin
            if (m_arm[k] && m_es[k] == nc) wk = 1;
            fire[k] = !m_h && m_arm[k] && m_es[k] == m_cnt;
            if (fire[k]) begin
                hit_any = 1;
                if (m_el[k] < best) best = m_el[k];
            end
        end
        s = 0;
        for (int k = 0; k < 4; k++) if (m_sv[k] && m_sa[k] == int'(ret_pc_post)) s = 1;
        l = (ret_pc_pre == ret_pc_post);
        i = ret_idle && !wk;
        x = (nc >= m_max);
        if (clr_halt) begin
            m_h = 0; m_r = 0; m_cnt = 0;
        end else if (ret_valid && !m_h) begin
            m_cnt = nc;
            if (s || l || i || x) begin
                m_h = 1;
                m_r = s ? 1 : l ? 2 : i ? 0 : 3;
            end
        end
        for (int k = 0; k < 4; k++) if (fire[k]) m_arm[k] = 0;
        m_irq = hit_any;
        if (hit_any) m_lvl = best;
        if (cfg_we) begin
            if (cfg_addr < 4) begin
                m_sv[cfg_addr] = cfg_wdata[16];
                m_sa[cfg_addr] = int'(cfg_wdata[15:0]);
            end else if (cfg_addr < 8) begin
                m_arm[cfg_addr-4] = cfg_wdata[31];
                m_el[cfg_addr-4]  = int'(cfg_wdata[27:24]);
                m_es[cfg_addr-4]  = int'(cfg_wdata[23:0]);
            end else if (cfg_addr == 8) begin
                m_max = int'(cfg_wdata[23:0]);
            end
        end
    endtask

    task automatic tick();
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R7", "halted", int'(halted), int'(m_h));
        chk("R7", "halt_reason", int'(halt_reason), m_r);
        chk("R2", "step_count", int'(step_count), m_cnt);
        chk("R9", "irq_req", int'(irq_req), int'(m_irq));
        if (m_irq) chk("R10", "irq_level", int'(irq_level), m_lvl);
        rst = 0; clr_halt = 0; cfg_we = 0; ret_valid = 0; ret_idle = 0; irq_pending = 0;
    endtask

    task automatic cfg(input int a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d; tick();
    endtask

    task automatic ret(input int pre, input int post, input bit idl, input bit pend);
        ret_valid = 1; ret_pc_pre = 16'(pre); ret_pc_post = 16'(post);
        ret_idle = idl; irq_pending = pend; tick();
    endtask

    task automatic clear();
        clr_halt = 1; tick();
    endtask

    task automatic run_seq(input int base, input int n);
        for (int k = 0; k < n; k++) ret(base + 2*k, base + 2*k + 2, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; clr_halt = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        ret_valid = 0; ret_pc_pre = 0; ret_pc_post = 0; ret_idle = 0; irq_pending = 0;
        @(negedge clk);
        rst = 1; tick();
        rst = 1; tick();
        chk("R1", "reset halted", int'(halted), 0);
        chk("R1", "reset step_count", int'(step_count), 0);
        chk("R1", "reset irq_req", int'(irq_req), 0);
        chk("R1", "reset reason", int'(halt_reason), 0);

        run_seq(16'h0100, 20);
        chk("R2", "count after 20", int'(step_count), 20);
        chk("R1", "no halt under default limit", int'(halted), 0);

        // Stop addresses: entry 0 enabled, entry 1 disabled
        cfg(0, 32'h0001_0140);
        cfg(1, 32'h0000_0130);
        run_seq(16'h0128, 4);
        chk("R3", "disabled entry ignored", int'(halted), 0);
        run_seq(16'h0130, 8);
        chk("R3", "stop halted", int'(halted), 1);
        chk("R3", "stop reason", int'(halt_reason), 1);
        chk("R11", "halting retire counted", int'(step_count), 32);
        run_seq(16'h0400, 3);
        chk("R8", "retires ignored while halted", int'(step_count), 32);
        clear();
        chk("R8", "clear drops halt", int'(halted), 0);
        chk("R8", "clear zeroes count", int'(step_count), 0);

        // Loop
        ret(16'h0200, 16'h0200, 0, 0);
        chk("R4", "loop reason", int'(halt_reason), 2);
        clear();

        // Idle
        ret(16'h0300, 16'h0302, 1, 0);
        chk("R5", "idle reason", int'(halted) * 4 + int'(halt_reason), 4);
        clear();
        ret(16'h0300, 16'h0302, 1, 1);
        chk("R5", "pending wakes idle", int'(halted), 0);
        cfg(4, 32'h8500_0002);
        ret(16'h0302, 16'h0304, 1, 0);
        chk("R5", "scheduled irq wakes idle", int'(halted), 0);
        tick();
        chk("R9", "irq pulse", int'(irq_req), 1);
        chk("R9", "irq level", int'(irq_level), 5);
        tick();
        chk("R9", "irq single pulse", int'(irq_req), 0);
        clear();

        // Step limit
        cfg(8, 32'h0000_0004);
        run_seq(16'h0500, 4);
        chk("R6", "limit reason", int'(halt_reason), 3);
        chk("R6", "limit count", int'(step_count), 4);
        clear();

        // Priorities
        ret(16'h0140, 16'h0140, 0, 0);
        chk("R7", "stop over loop", int'(halt_reason), 1);
        clear();
        ret(16'h0050, 16'h0050, 1, 0);
        chk("R7", "loop over idle", int'(halt_reason), 2);
        clear();
        run_seq(16'h0600, 3);
        ret(16'h0606, 16'h0608, 1, 0);
        chk("R7", "idle over limit", int'(halted) * 4 + int'(halt_reason), 4);
        clear();
        run_seq(16'h0600, 3);
        ret(16'h0700, 16'h0140, 0, 0);
        chk("R7", "stop over limit", int'(halt_reason), 1);
        clear();
        cfg(8, 32'h00FF_FFFF);

        // Simultaneous scheduled entries
        cfg(5, 32'h8900_0006);
        cfg(6, 32'h8200_0006);
        cfg(7, 32'h8700_0008);
        run_seq(16'h0800, 6);
        tick();
        chk("R10", "tie picks lowest level", int'(irq_level), 2);
        chk("R10", "tie request", int'(irq_req), 1);
        tick();
        chk("R10", "tied entries all disarmed", int'(irq_req), 0);
        run_seq(16'h0900, 2);
        tick();
        chk("R9", "later entry level", int'(irq_level), 7);
        repeat (3) tick();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule